// File: doc/BRIEF.md
# DMA Channel Set/Clear Control Register File

This block is the register file that sits between the CPU bus and a 32-channel DMA engine. For every channel it holds four flags: request enable, error-interrupt enable, interrupt pending and error pending. Software changes any one flag with a single byte write that carries a channel number to a dedicated command port. No read-modify-write sequence is needed, and two agents working on different channels never race. The four flag bitmaps can be read back as 32-bit words. A control word holds the engine's global arbitration and halt options and drives them out to the datapath.

Hardware raises the pending flags through one-cycle set vectors, one for interrupts and one for errors. An error-status word records the channel of the most recent error and reports whether any error is still pending. Two command ports do not touch stored state. Instead they emit a one-cycle per-channel pulse to the transfer datapath: one pulse starts a channel and the other clears its done flag. The block drives two IRQ lines. One is the transfer-complete line and the other is the error line, which is gated by the error-interrupt enables.

The bus side is a plain single-cycle write strobe with byte enables and a combinational read path. It has no back-pressure: every write is accepted in the cycle its strobe is high, and read data follows the address in the same cycle.

Top module: `dma_chan_ctl_regs`

## Requirements
- R1: After reset, every bitmap, the control word and the error-status word read 0, both IRQ outputs are low, and `req_en`, `start_pulse` and `done_clr` are 0.
- R2: A byte written to offset 0x1B (lane 3 of word 0x18) sets the request-enable bit of the channel given by its low 5 bits. A byte written to 0x1A (lane 2) clears that bit. Bits 7:5 of the byte are ignored. The bitmap reads back at 0x0C and is driven on `req_en`.
- R3: A byte written to 0x19 (lane 1) sets the error-interrupt-enable bit of the channel in its low 5 bits. A byte written to 0x18 (lane 0) clears it. The bitmap reads back at 0x14, and the request-enable bitmap is not affected.
- R4: A 1 on `hw_int_set[n]` sets bit n of the interrupt-pending bitmap, which reads at 0x24. A byte written to 0x1F (lane 3 of word 0x1C) clears only the named channel's bit.
- R5: A 1 on `hw_err_set[n]` sets bit n of the error-pending bitmap, which reads at 0x2C. A byte written to 0x1E (lane 2 of word 0x1C) clears only the named channel's bit.
- R6: If a hardware set and a software clear hit the same pending bit in one cycle, the bit ends up set. If one write both sets and clears the same enable bit through two lanes, the bit ends up set.
- R7: `irq_xfer` is high exactly when any interrupt-pending bit is set. `irq_err` is high exactly when some channel has both its error-pending bit and its error-interrupt-enable bit set.
- R8: The error-status word at 0x04 holds, in bits 4:0, the channel of the most recent hardware error; when several errors arrive in one cycle, the lowest channel number is kept. That field keeps its value after the errors are cleared. Bit 31 reads 1 while any error-pending bit is set, and all other bits read 0.
- R9: The control word at 0x00 is written per byte lane. Only bits 1 to 7, 16 and 17 are stored; every other bit reads 0. The stored value is driven on `ctrl_out`.
- R10: A byte written to 0x1D (lane 1 of word 0x1C) produces a one-cycle pulse on `start_pulse` for that channel. A byte written to 0x1C (lane 0) does the same on `done_clr`. Both pulses are high in the cycle after the write.
- R11: Each enabled lane of one write acts as its own command. Reads of unmapped or non-word-aligned addresses return 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 6 | Byte address of the word accessed |
| bus_be | input | 4 | Byte-lane enables, lane k = bus_wdata[8k+7:8k] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| hw_int_set | input | 32 | Per-channel interrupt set from the datapath |
| hw_err_set | input | 32 | Per-channel error set from the datapath |
| ctrl_out | output | 32 | Stored control word |
| req_en | output | 32 | Request-enable bitmap |
| start_pulse | output | 32 | One-cycle channel start pulses |
| done_clr | output | 32 | One-cycle done-clear pulses |
| irq_xfer | output | 1 | Transfer interrupt line |
| irq_err | output | 1 | Error interrupt line |

## Verification
The assertions assume that the hardware set vectors are quiet while reset is active. They also assume that a rise on either IRQ line can only follow a hardware set or a bus write in the cycle before. The bench drives the set vectors only through a task that holds them for exactly one clock and then returns them to zero. It issues every bus write as a single-cycle strobe changed on the falling edge, so the interrupt-clear assertion always sees a stable channel number in the upper data byte.

// File: rtl/dma_ctl_pkg.sv
package dma_ctl_pkg;
  localparam logic [7:0] OFF_CTRL   = 8'h00;
  localparam logic [7:0] OFF_ESTAT  = 8'h04;
  localparam logic [7:0] OFF_ERQ    = 8'h0C;
  localparam logic [7:0] OFF_EEI    = 8'h14;
  localparam logic [7:0] OFF_CMD_LO = 8'h18;
  localparam logic [7:0] OFF_CMD_HI = 8'h1C;
  localparam logic [7:0] OFF_INT    = 8'h24;
  localparam logic [7:0] OFF_ERR    = 8'h2C;

  localparam logic [31:0] CTRL_MASK = 32'h0003_00FE;

  // op index = {command word is the upper one, byte lane}
  typedef enum logic [2:0] {
    OP_CLR_EEI   = 3'd0,
    OP_SET_EEI   = 3'd1,
    OP_CLR_ERQ   = 3'd2,
    OP_SET_ERQ   = 3'd3,
    OP_CLR_DONE  = 3'd4,
    OP_SET_START = 3'd5,
    OP_CLR_ERR   = 3'd6,
    OP_CLR_INT   = 3'd7
  } cmd_op_e;
endpackage

// File: rtl/dma_cmd_decode.sv
module dma_cmd_decode
  import dma_ctl_pkg::*;
#(
  parameter int NCH = 32,
  parameter int AW  = 6,
  localparam int CHW = $clog2(NCH)
) (
  input  logic                     wr,
  input  logic [AW-1:0]            addr,
  input  logic [3:0]               be,
  input  logic [3:0][CHW-1:0]      lane_ch,
  output logic [7:0][NCH-1:0]      op_hit,
  output logic [3:0]               ctrl_be
);
  logic lo_hit, hi_hit;

  assign lo_hit  = wr && (addr == AW'(OFF_CMD_LO));
  assign hi_hit  = wr && (addr == AW'(OFF_CMD_HI));
  assign ctrl_be = (wr && (addr == AW'(OFF_CTRL))) ? be : 4'b0000;

  for (genvar l = 0; l < 4; l++) begin : g_lane
    logic [NCH-1:0] ch_vec;
    assign ch_vec        = NCH'(1) << lane_ch[l];
    assign op_hit[l]     = (lo_hit && be[l]) ? ch_vec : '0;
    assign op_hit[4 + l] = (hi_hit && be[l]) ? ch_vec : '0;
  end
endmodule

// File: rtl/dma_chan_bitmap.sv
module dma_chan_bitmap #(
  parameter int NCH = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] set,
  input  logic [NCH-1:0] clr,
  output logic [NCH-1:0] q
);
  // a set in the same cycle as a clear leaves the bit set
  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= (q & ~clr) | set;
  end
endmodule

// File: rtl/dma_err_track.sv
module dma_err_track #(
  parameter int NCH = 32,
  localparam int CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] err_set,
  output logic [CHW-1:0] last_ch
);
  logic [CHW-1:0] first_ch;

  always_comb begin
    first_ch = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (err_set[i]) first_ch = CHW'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          last_ch <= '0;
    else if (|err_set)   last_ch <= first_ch;
  end
endmodule

// File: rtl/dma_chan_ctl_regs.sv
module dma_chan_ctl_regs
  import dma_ctl_pkg::*;
#(
  parameter int NCH = 32,
  parameter int AW  = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_wr,
  input  logic [AW-1:0]  bus_addr,
  input  logic [3:0]     bus_be,
  input  logic [31:0]    bus_wdata,
  output logic [31:0]    bus_rdata,
  input  logic [NCH-1:0] hw_int_set,
  input  logic [NCH-1:0] hw_err_set,
  output logic [31:0]    ctrl_out,
  output logic [NCH-1:0] req_en,
  output logic [NCH-1:0] start_pulse,
  output logic [NCH-1:0] done_clr,
  output logic           irq_xfer,
  output logic           irq_err
);
  localparam int CHW = $clog2(NCH);
  localparam int NBM = 4;  // 0 request enable, 1 error-int enable, 2 int pending, 3 err pending

  logic [3:0][CHW-1:0]   lane_ch;
  logic [7:0][NCH-1:0]   op_hit;
  logic [3:0]            ctrl_be;
  logic [NBM-1:0][NCH-1:0] bm_set, bm_clr, bm_q;
  logic [NCH-1:0]        eei_q, int_pend, err_pend;
  logic [CHW-1:0]        last_ch;
  logic [31:0]           ctrl_q;

  for (genvar l = 0; l < 4; l++) begin : g_ch
    assign lane_ch[l] = bus_wdata[8*l +: CHW];
  end

  dma_cmd_decode #(.NCH(NCH), .AW(AW)) u_dec (
    .wr      (bus_wr),
    .addr    (bus_addr),
    .be      (bus_be),
    .lane_ch (lane_ch),
    .op_hit  (op_hit),
    .ctrl_be (ctrl_be)
  );

  assign bm_set[0] = op_hit[OP_SET_ERQ];
  assign bm_clr[0] = op_hit[OP_CLR_ERQ];
  assign bm_set[1] = op_hit[OP_SET_EEI];
  assign bm_clr[1] = op_hit[OP_CLR_EEI];
  assign bm_set[2] = hw_int_set;
  assign bm_clr[2] = op_hit[OP_CLR_INT];
  assign bm_set[3] = hw_err_set;
  assign bm_clr[3] = op_hit[OP_CLR_ERR];

  for (genvar b = 0; b < NBM; b++) begin : g_bm
    dma_chan_bitmap #(.NCH(NCH)) u_bm (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (bm_set[b]),
      .clr   (bm_clr[b]),
      .q     (bm_q[b])
    );
  end

  assign req_en   = bm_q[0];
  assign eei_q    = bm_q[1];
  assign int_pend = bm_q[2];
  assign err_pend = bm_q[3];

  dma_err_track #(.NCH(NCH)) u_err (
    .clk     (clk),
    .rst_n   (rst_n),
    .err_set (hw_err_set),
    .last_ch (last_ch)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q      <= '0;
      start_pulse <= '0;
      done_clr    <= '0;
    end else begin
      start_pulse <= op_hit[OP_SET_START];
      done_clr    <= op_hit[OP_CLR_DONE];
      for (int k = 0; k < 4; k++)
        if (ctrl_be[k]) ctrl_q[8*k +: 8] <= bus_wdata[8*k +: 8] & CTRL_MASK[8*k +: 8];
    end
  end

  assign ctrl_out = ctrl_q;
  assign irq_xfer = |int_pend;
  assign irq_err  = |(err_pend & eei_q);

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      AW'(OFF_CTRL):  bus_rdata = ctrl_q;
      AW'(OFF_ESTAT): bus_rdata = {|err_pend, 31'(last_ch)};
      AW'(OFF_ERQ):   bus_rdata = 32'(req_en);
      AW'(OFF_EEI):   bus_rdata = 32'(eei_q);
      AW'(OFF_INT):   bus_rdata = 32'(int_pend);
      AW'(OFF_ERR):   bus_rdata = 32'(err_pend);
      default:        bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dma_chan_ctl_regs_chk.sv
module dma_chan_ctl_regs_chk #(
  parameter int NCH = 32,
  parameter int AW  = 6,
  localparam int CHW = $clog2(NCH)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bus_wr,
  input logic [AW-1:0]  bus_addr,
  input logic [3:0]     bus_be,
  input logic [31:0]    bus_wdata,
  input logic [NCH-1:0] hw_int_set,
  input logic [NCH-1:0] hw_err_set,
  input logic [NCH-1:0] req_en,
  input logic [NCH-1:0] int_pend,
  input logic [NCH-1:0] err_pend,
  input logic [NCH-1:0] start_pulse,
  input logic           irq_xfer,
  input logic           irq_err
);
  p_hw_int_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_int_set != '0) |=> ((int_pend & $past(hw_int_set)) == $past(hw_int_set)));

  p_hw_err_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_err_set != '0) |=> ((err_pend & $past(hw_err_set)) == $past(hw_err_set)));

  p_int_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(8'h1C) && bus_be[3] && !hw_int_set[bus_wdata[24 +: CHW]])
    |=> !int_pend[$past(bus_wdata[24 +: CHW])]);

  p_erq_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(req_en));

  p_xfer_irq_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_xfer) |-> ($past(hw_int_set) != '0));

  p_err_irq_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_err) |-> ($past(hw_err_set) != '0 || $past(bus_wr)));

  p_start_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(start_pulse));
endmodule

bind dma_chan_ctl_regs dma_chan_ctl_regs_chk #(.NCH(NCH), .AW(AW)) u_chk (.*);

// File: tb/dma_chan_ctl_regs_tb.sv
module dma_chan_ctl_regs_tb;
  localparam int NCH = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] hw_int_set = '0, hw_err_set = '0;
  logic [31:0] ctrl_out, req_en, start_pulse, done_clr;
  logic        irq_xfer, irq_err;

  int n_tests = 0, n_fail = 0;
  logic [31:0] e_erq = '0, e_eei = '0, e_int = '0, e_err = '0;
  logic [4:0]  e_last = '0;
  logic [31:0] rv;

  always #10 clk = ~clk;

  dma_chan_ctl_regs #(.NCH(NCH), .AW(6)) u_dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = '0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic hw(input logic [31:0] i, input logic [31:0] e);
    @(negedge clk);
    hw_int_set = i; hw_err_set = e;
    @(negedge clk);
    hw_int_set = '0; hw_err_set = '0;
    e_int |= i; e_err |= e;
    if (e != 0)
      for (int k = 31; k >= 0; k--) if (e[k]) e_last = 5'(k);
  endtask

  function automatic logic [31:0] estat();
    return {(e_err != 0), 26'b0, e_last};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    foreach (rv[k]) begin end
    rd(6'h00, rv); chk("R1 ctrl", rv, 0);
    rd(6'h04, rv); chk("R1 estat", rv, 0);
    rd(6'h0C, rv); chk("R1 erq", rv, 0);
    rd(6'h14, rv); chk("R1 eei", rv, 0);
    rd(6'h24, rv); chk("R1 int", rv, 0);
    rd(6'h2C, rv); chk("R1 err", rv, 0);
    chk("R1 outs", {irq_xfer, irq_err, 30'(req_en | start_pulse | done_clr)}, 0);

    // R2 request enable sweep, upper command bits garbage
    for (int ch = 0; ch < NCH; ch++) begin
      wr(6'h18, 4'b1000, {8'(ch) | 8'hE0, 24'h0});
      e_erq |= 32'(1) << ch;
      rd(6'h0C, rv); chk("R2 set erq", rv, e_erq);
      chk("R2 req_en", req_en, e_erq);
    end
    for (int ch = 1; ch < NCH; ch += 2) begin
      wr(6'h18, 4'b0100, {8'h0, 8'(ch) | 8'hA0, 16'h0});
      e_erq &= ~(32'(1) << ch);
      rd(6'h0C, rv); chk("R2 clr erq", rv, e_erq);
    end

    // R3 error-interrupt enable sweep
    for (int ch = 0; ch < NCH; ch++) begin
      wr(6'h18, 4'b0010, {16'h0, 8'(ch) | 8'h60, 8'h0});
      e_eei |= 32'(1) << ch;
      rd(6'h14, rv); chk("R3 set eei", rv, e_eei);
    end
    for (int ch = 1; ch < NCH; ch += 2) begin
      wr(6'h18, 4'b0001, {24'h0, 8'(ch) | 8'hE0});
      e_eei &= ~(32'(1) << ch);
      rd(6'h14, rv); chk("R3 clr eei", rv, e_eei);
    end
    rd(6'h0C, rv); chk("R3 erq untouched", rv, e_erq);

    // R4 / R7 interrupt pending sweep
    for (int ch = 0; ch < NCH; ch++) begin
      hw(32'(1) << ch, 0);
      rd(6'h24, rv); chk("R4 int set", rv, e_int);
      chk("R7 irq_xfer on", 32'(irq_xfer), 1);
    end
    for (int ch = 0; ch < NCH; ch++) begin
      wr(6'h1C, 4'b1000, {8'(ch), 24'h0});
      e_int &= ~(32'(1) << ch);
      rd(6'h24, rv); chk("R4 int clr one", rv, e_int);
      chk("R7 irq_xfer", 32'(irq_xfer), 32'(e_int != 0));
    end

    // R5 / R7 / R8 error pending sweep
    for (int ch = 0; ch < NCH; ch++) begin
      hw(0, 32'(1) << ch);
      rd(6'h2C, rv); chk("R5 err set", rv, e_err);
      rd(6'h04, rv); chk("R8 estat", rv, estat());
      chk("R7 irq_err", 32'(irq_err), 32'((e_err & e_eei) != 0));
    end
    for (int ch = NCH - 1; ch >= 0; ch--) begin
      wr(6'h1C, 4'b0100, {8'h0, 8'(ch), 16'h0});
      e_err &= ~(32'(1) << ch);
      rd(6'h2C, rv); chk("R5 err clr one", rv, e_err);
      rd(6'h04, rv); chk("R8 estat keep", rv, estat());
      chk("R7 irq_err", 32'(irq_err), 32'((e_err & e_eei) != 0));
    end
    hw(0, 32'(1) << 3);
    chk("R7 irq_err masked ch3", 32'(irq_err), 0);
    hw(0, 32'(1) << 4);
    chk("R7 irq_err enabled ch4", 32'(irq_err), 1);
    rd(6'h04, rv); chk("R8 estat ch4", rv, estat());

    // R8 several errors in one cycle: lowest channel kept
    hw(0, (32'(1) << 20) | (32'(1) << 9));
    rd(6'h04, rv); chk("R8 estat lowest", rv, estat());
    chk("R8 lowest is 9", 32'(e_last), 9);

    // R6 set wins over clear
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 6'h1C; bus_be = 4'b1000; bus_wdata = {8'd5, 24'h0};
    hw_int_set = 32'(1) << 5;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = '0; hw_int_set = '0;
    e_int |= 32'(1) << 5;
    rd(6'h24, rv); chk("R6 int set wins", rv, e_int);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 6'h1C; bus_be = 4'b1000; bus_wdata = {8'd5, 24'h0};
    hw_int_set = 32'(1) << 6;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = '0; hw_int_set = '0;
    e_int = (e_int & ~(32'(1) << 5)) | (32'(1) << 6);
    rd(6'h24, rv); chk("R6 other channel", rv, e_int);
    wr(6'h18, 4'b0011, {16'h0, 8'd9, 8'd9});
    e_eei |= 32'(1) << 9;
    rd(6'h14, rv); chk("R6 eei set wins", rv, e_eei);

    // R9 control word
    wr(6'h00, 4'b1111, 32'hFFFF_FFFF);
    rd(6'h00, rv); chk("R9 ctrl mask", rv, 32'h0003_00FE);
    chk("R9 ctrl_out", ctrl_out, 32'h0003_00FE);
    wr(6'h00, 4'b0001, 32'h0000_0000);
    rd(6'h00, rv); chk("R9 ctrl lane", rv, 32'h0003_0000);

    // R10 pulses
    wr(6'h1C, 4'b0010, {16'h0, 8'd7, 8'h0});
    chk("R10 start pulse", start_pulse, 32'(1) << 7);
    chk("R10 no done", done_clr, 0);
    @(negedge clk);
    chk("R10 start ends", start_pulse, 0);
    wr(6'h1C, 4'b0001, {24'h0, 8'd12});
    chk("R10 done pulse", done_clr, 32'(1) << 12);
    @(negedge clk);
    chk("R10 done ends", done_clr, 0);

    // R11 multi-lane write and unmapped space
    hw(32'(1) << 2, 32'(1) << 2);
    wr(6'h1C, 4'b1100, {8'd2, 8'd2, 16'h0});
    e_int &= ~(32'(1) << 2); e_err &= ~(32'(1) << 2);
    rd(6'h24, rv); chk("R11 int lane", rv, e_int);
    rd(6'h2C, rv); chk("R11 err lane", rv, e_err);
    rd(6'h30, rv); chk("R11 unmapped", rv, 0);
    rd(6'h0D, rv); chk("R11 misaligned", rv, 0);
    wr(6'h1B, 4'b1000, {8'd1, 24'h0});
    rd(6'h0C, rv); chk("R11 misaligned write", rv, e_erq);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule